// File: doc/BRIEF.md
# Table Pointer Byte Access Unit

This block gives a processor byte-granular access to a 16-bit-wide program memory. Software loads a 22-bit byte pointer through three 8-bit pointer registers (low, high and upper) and an 8-bit data latch. It then issues table commands. A table read fetches the addressed byte into the latch. A table write presents the latch byte to the memory together with a one-cycle write strobe. Each command carries a pointer-update mode: leave the pointer alone, step it up or down after the access, or step it up before the access.

The pointer's lowest bit chooses the high or low half of a memory word, and the remaining 21 bits form the word address. The top pointer bit selects configuration space. Steps never touch that bit: they act only on the 21-bit linear field, which wraps around at both ends. Memory read data is taken to arrive one clock after the address. The unit raises a busy flag for that cycle and ignores new commands until the byte has been captured.

Top module: `tbl_access_unit`

## Requirements
- R1: After a synchronous reset the pointer and the latch read back as zero, and busy is low.
- R2: Register select codes are 0 = pointer low byte, 1 = pointer high byte, 2 = pointer upper byte, 3 = latch, for both writes and readback. The upper register holds pointer bits 21:16, reads 0 in bits 7:6, and ignores writes to those bits.
- R3: Mode codes are 0 = pointer unchanged, 1 = step up after the access, 2 = step down after the access, 3 = step up before the access. The pointer holds its resulting value from the clock edge that ends the accepted command cycle.
- R4: A step changes only pointer bits 20:0, modulo 2^21. Bit 21 is never altered by a step.
- R5: During an accepted command cycle, mem_addr carries bits 21:1 of the access pointer and mem_byte_hi carries bit 0 (1 = high byte). For mode 3 the access pointer is the incremented value; for the other modes it is the current pointer.
- R6: An accepted read raises mem_rd_en for that cycle only. Busy is high in the next cycle, and at the end of that cycle the latch takes mem_rdata[15:8] if the byte select was 1, or mem_rdata[7:0] if it was 0.
- R7: An accepted write raises mem_wr_en for that cycle only, with mem_wdata equal to the latch. Busy does not rise for a write.
- R8: A command presented while busy is high is ignored: no memory strobe and no pointer change.
- R9: A software write to any pointer byte in the same cycle as an accepted command takes effect, and that command's pointer update is dropped. The access itself still uses the pre-write pointer.
- R10: A software write to the latch in the same cycle as a read capture wins over the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software register write enable |
| sw_sel | input | 2 | Register select for writes |
| sw_wdata | input | 8 | Software write data |
| sw_rd_sel | input | 2 | Register select for readback |
| sw_rdata | output | 8 | Readback data |
| cmd_valid | input | 1 | Table command request |
| cmd_write | input | 1 | 1 = table write, 0 = table read |
| cmd_mode | input | 2 | Pointer-update mode |
| busy | output | 1 | Read capture pending |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 21 | Word address |
| mem_byte_hi | output | 1 | Byte select within the word |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 16 | Memory word, valid one clock after the read strobe |

## Verification
The assertions assume that the memory returns a stable word during the busy cycle that follows a read strobe. The bench's memory model registers a computed word on every read strobe, so this assumption holds. The properties also rely on the synchronous reset leaving busy low. No assumption is placed on command timing, so the stimulus deliberately issues commands while busy and software writes in the same cycle as commands and captures, which exercises the ignore and precedence rules directly.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
    localparam int PTR_W   = 22;
    localparam int LIN_W   = PTR_W - 1;
    localparam int WORD_AW = PTR_W - 1;
    localparam int BYTE_W  = 8;
    localparam int UP_W    = PTR_W - 2 * BYTE_W;
    localparam int MWORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        UPD_NONE     = 2'd0,
        UPD_POST_INC = 2'd1,
        UPD_POST_DEC = 2'd2,
        UPD_PRE_INC  = 2'd3
    } upd_mode_e;

    typedef enum logic [1:0] {
        SEL_LO    = 2'd0,
        SEL_HI    = 2'd1,
        SEL_UP    = 2'd2,
        SEL_LATCH = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              space;
        logic [LIN_W-1:0]  lin;
    } tptr_t;

    typedef struct packed {
        logic               rd;
        logic               wr;
        logic [WORD_AW-1:0] word;
        logic               hi;
    } mem_req_t;

    function automatic tptr_t ptr_step(tptr_t p, logic down);
        tptr_t r;
        r.space = p.space;
        r.lin   = down ? p.lin - 1'b1 : p.lin + 1'b1;
        return r;
    endfunction

    function automatic tptr_t ptr_after(tptr_t p, upd_mode_e m);
        case (m)
            UPD_POST_INC, UPD_PRE_INC: return ptr_step(p, 1'b0);
            UPD_POST_DEC:              return ptr_step(p, 1'b1);
            default:                   return p;
        endcase
    endfunction
endpackage

// File: rtl/tbl_ptr_reg.sv
module tbl_ptr_reg
    import tbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  reg_sel_e         sw_sel,
    input  logic [BYTE_W-1:0] sw_data,
    input  logic             upd_en,
    input  upd_mode_e        upd_mode,
    output tptr_t            ptr
);
    logic  [PTR_W-1:0] ptr_q;
    logic              sw_hit;
    tptr_t             ptr_next;

    assign sw_hit   = sw_we && (sw_sel != SEL_LATCH);
    assign ptr_next = ptr_after(tptr_t'(ptr_q), upd_mode);
    assign ptr      = tptr_t'(ptr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (sw_hit) begin
            case (sw_sel)
                SEL_LO:  ptr_q[BYTE_W-1:0]          <= sw_data;
                SEL_HI:  ptr_q[2*BYTE_W-1:BYTE_W]   <= sw_data;
                default: ptr_q[PTR_W-1:2*BYTE_W]    <= sw_data[UP_W-1:0];
            endcase
        end else if (upd_en) begin
            ptr_q <= ptr_next;
        end
    end

    assert_space_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !sw_hit) |=> ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1]));

    assert_none_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !sw_hit && upd_mode == UPD_NONE) |=> $stable(ptr_q));

    assert_sw_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (sw_we && sw_sel == SEL_LO) |=> ptr_q[BYTE_W-1:0] == $past(sw_data));
endmodule

// File: rtl/tbl_mem_if.sv
module tbl_mem_if
    import tbl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  upd_mode_e          cmd_mode,
    input  tptr_t              ptr,
    input  logic [MWORD_W-1:0] mem_rdata,
    output logic               accept,
    output mem_req_t           req,
    output logic               busy,
    output logic               cap_en,
    output logic [BYTE_W-1:0]  cap_byte
);
    tptr_t acc_ptr;
    logic  busy_q;
    logic  hi_q;

    assign accept  = cmd_valid && !busy_q;
    assign acc_ptr = (cmd_mode == UPD_PRE_INC) ? ptr_step(ptr, 1'b0) : ptr;

    always_comb begin
        req.rd   = accept && !cmd_write;
        req.wr   = accept && cmd_write;
        req.word = acc_ptr[PTR_W-1:1];
        req.hi   = acc_ptr[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            hi_q   <= 1'b0;
        end else begin
            busy_q <= req.rd;
            if (req.rd) hi_q <= req.hi;
        end
    end

    assign busy     = busy_q;
    assign cap_en   = busy_q;
    assign cap_byte = hi_q ? mem_rdata[MWORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];

    assert_rd_then_busy_R6: assert property (@(posedge clk) disable iff (rst)
        req.rd |=> busy);

    assert_busy_single_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    assert_quiet_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!req.rd && !req.wr));

    assert_wr_no_busy_R7: assert property (@(posedge clk) disable iff (rst)
        req.wr |=> !busy);
endmodule

// File: rtl/tbl_latch.sv
module tbl_latch
    import tbl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [BYTE_W-1:0] sw_data,
    input  logic              cap_en,
    input  logic [BYTE_W-1:0] cap_byte,
    output logic [BYTE_W-1:0] latch
);
    always_ff @(posedge clk) begin
        if (rst)         latch <= '0;
        else if (sw_we)  latch <= sw_data;
        else if (cap_en) latch <= cap_byte;
    end

    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && !cap_en) |=> $stable(latch));

    assert_sw_over_cap_R10: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> latch == $past(sw_data));
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit
    import tbl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_we,
    input  logic [1:0]          sw_sel,
    input  logic [BYTE_W-1:0]   sw_wdata,
    input  logic [1:0]          sw_rd_sel,
    output logic [BYTE_W-1:0]   sw_rdata,
    input  logic                cmd_valid,
    input  logic                cmd_write,
    input  logic [1:0]          cmd_mode,
    output logic                busy,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [WORD_AW-1:0]  mem_addr,
    output logic                mem_byte_hi,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic [MWORD_W-1:0]  mem_rdata
);
    tptr_t             ptr;
    mem_req_t          req;
    logic              accept;
    logic              cap_en;
    logic [BYTE_W-1:0] cap_byte;
    logic [BYTE_W-1:0] latch;
    logic [PTR_W-1:0]  ptr_v;
    logic              latch_we;

    assign latch_we = sw_we && (reg_sel_e'(sw_sel) == SEL_LATCH);
    assign ptr_v    = ptr;

    tbl_ptr_reg u_ptr (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_sel   (reg_sel_e'(sw_sel)),
        .sw_data  (sw_wdata),
        .upd_en   (accept),
        .upd_mode (upd_mode_e'(cmd_mode)),
        .ptr      (ptr)
    );

    tbl_mem_if u_mif (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_mode  (upd_mode_e'(cmd_mode)),
        .ptr       (ptr),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .req       (req),
        .busy      (busy),
        .cap_en    (cap_en),
        .cap_byte  (cap_byte)
    );

    tbl_latch u_lat (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (latch_we),
        .sw_data  (sw_wdata),
        .cap_en   (cap_en),
        .cap_byte (cap_byte),
        .latch    (latch)
    );

    assign mem_rd_en   = req.rd;
    assign mem_wr_en   = req.wr;
    assign mem_addr    = req.word;
    assign mem_byte_hi = req.hi;
    assign mem_wdata   = latch;

    always_comb begin
        case (reg_sel_e'(sw_rd_sel))
            SEL_LO:  sw_rdata = ptr_v[BYTE_W-1:0];
            SEL_HI:  sw_rdata = ptr_v[2*BYTE_W-1:BYTE_W];
            SEL_UP:  sw_rdata = {{(BYTE_W-UP_W){1'b0}}, ptr_v[PTR_W-1:2*BYTE_W]};
            default: sw_rdata = latch;
        endcase
    end

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/sim_tbl_access_unit.sv
module sim_tbl_access_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_sel = 2'd0;
    logic [7:0]  sw_wdata = 8'd0;
    logic [1:0]  sw_rd_sel = 2'd0;
    logic [7:0]  sw_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic [1:0]  cmd_mode = 2'd0;
    logic        busy;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [20:0] mem_addr;
    logic        mem_byte_hi;
    logic [7:0]  mem_wdata;
    logic [15:0] mem_rdata = 16'd0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [21:0] m_ptr;
    logic [7:0]  m_lat;
    bit          m_busy;
    logic [21:0] m_pend;

    always #10 clk = ~clk;

    tbl_access_unit u0 (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .sw_rd_sel(sw_rd_sel), .sw_rdata(sw_rdata), .cmd_valid(cmd_valid),
        .cmd_write(cmd_write), .cmd_mode(cmd_mode), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_byte_hi(mem_byte_hi), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] mem_word(logic [20:0] w);
        int v;
        v = int'(w) ^ (int'(w) >> 5);
        return 16'(v * 40503 + 17);
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [21:0] step(logic [21:0] p, bit down);
        logic [20:0] l;
        l = down ? p[20:0] - 21'd1 : p[20:0] + 21'd1;
        return {p[21], l};
    endfunction

    task automatic readback(string req);
        for (int s = 0; s < 4; s++) begin
            sw_rd_sel = 2'(s);
            #1;
            case (s)
                0: chk(req, {24'd0, sw_rdata}, {24'd0, m_ptr[7:0]});
                1: chk(req, {24'd0, sw_rdata}, {24'd0, m_ptr[15:8]});
                2: chk(req, {24'd0, sw_rdata}, {26'd0, m_ptr[21:16]});
                default: chk(req, {24'd0, sw_rdata}, {24'd0, m_lat});
            endcase
        end
    endtask

    task automatic cyc(string req, bit we, logic [1:0] sel, logic [7:0] d,
                       bit cv, bit cw, logic [1:0] cm);
        logic [21:0] acc, np;
        logic [7:0]  nl;
        logic [15:0] w;
        bit          acpt;
        sw_we = we; sw_sel = sel; sw_wdata = d;
        cmd_valid = cv; cmd_write = cw; cmd_mode = cm;
        #1;
        acc  = (cm == 2'd3) ? step(m_ptr, 1'b0) : m_ptr;
        acpt = cv && !m_busy;
        chk({req, "/R6 rd"}, {31'd0, mem_rd_en}, {31'd0, acpt && !cw});
        chk({req, "/R7 wr"}, {31'd0, mem_wr_en}, {31'd0, acpt && cw});
        chk({req, "/R6 busy"}, {31'd0, busy}, {31'd0, m_busy});
        if (acpt) begin
            chk({req, "/R5 addr"}, {11'd0, mem_addr}, {11'd0, acc[21:1]});
            chk({req, "/R5 hi"}, {31'd0, mem_byte_hi}, {31'd0, acc[0]});
            if (cw) chk({req, "/R7 data"}, {24'd0, mem_wdata}, {24'd0, m_lat});
        end
        np = m_ptr;
        if (we && sel != 2'd3) begin
            case (sel)
                2'd0: np[7:0]   = d;
                2'd1: np[15:8]  = d;
                default: np[21:16] = d[5:0];
            endcase
        end else if (acpt) begin
            case (cm)
                2'd1, 2'd3: np = step(m_ptr, 1'b0);
                2'd2:       np = step(m_ptr, 1'b1);
                default:    np = m_ptr;
            endcase
        end
        nl = m_lat;
        if (we && sel == 2'd3) nl = d;
        else if (m_busy) begin
            w  = mem_word(m_pend[21:1]);
            nl = m_pend[0] ? w[15:8] : w[7:0];
        end
        @(posedge clk);
        m_ptr  = np;
        m_lat  = nl;
        m_busy = acpt && !cw;
        if (acpt) m_pend = acc;
        @(negedge clk);
        sw_we = 1'b0; cmd_valid = 1'b0;
        readback(req);
    endtask

    task automatic set_ptr(logic [21:0] p);
        cyc("R2 lo", 1, 2'd0, p[7:0], 0, 0, 2'd0);
        cyc("R2 hi", 1, 2'd1, p[15:8], 0, 0, 2'd0);
        cyc("R2 up", 1, 2'd2, {2'b11, p[21:16]}, 0, 0, 2'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_ptr = '0; m_lat = '0; m_busy = 0; m_pend = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        readback("R1 reset");
        chk("R1 busy", {31'd0, busy}, 32'd0);

        set_ptr(22'h3F1234);
        cyc("R2 latch", 1, 2'd3, 8'hA7, 0, 0, 2'd0);
        // reads in every mode
        cyc("R3 rd none", 0, 0, 0, 1, 0, 2'd0);
        cyc("R6 idle", 0, 0, 0, 0, 0, 2'd0);
        cyc("R3 rd postinc", 0, 0, 0, 1, 0, 2'd1);
        cyc("R8 busy ignore", 0, 0, 0, 1, 1, 2'd1);
        cyc("R3 rd postdec", 0, 0, 0, 1, 0, 2'd2);
        cyc("R6 idle", 0, 0, 0, 0, 0, 2'd0);
        cyc("R5 rd preinc", 0, 0, 0, 1, 0, 2'd3);
        cyc("R6 idle", 0, 0, 0, 0, 0, 2'd0);
        // writes in every mode
        cyc("R7 wr none", 0, 0, 0, 1, 1, 2'd0);
        cyc("R7 wr postinc", 0, 0, 0, 1, 1, 2'd1);
        cyc("R7 wr postdec", 0, 0, 0, 1, 1, 2'd2);
        cyc("R7 wr preinc", 0, 0, 0, 1, 1, 2'd3);
        // wrap with bit 21 set and clear
        set_ptr(22'h3FFFFF);
        cyc("R4 wrap up", 0, 0, 0, 1, 1, 2'd1);
        cyc("R4 wrap down", 0, 0, 0, 1, 1, 2'd2);
        set_ptr(22'h1FFFFF);
        cyc("R4 preinc wrap", 0, 0, 0, 1, 0, 2'd3);
        cyc("R6 idle", 0, 0, 0, 0, 0, 2'd0);
        cyc("R4 wrap down0", 0, 0, 0, 1, 1, 2'd2);
        // collisions
        cyc("R9 sw vs upd", 1, 2'd0, 8'h5E, 1, 1, 2'd1);
        cyc("R9 sw up vs upd", 1, 2'd2, 8'h2B, 1, 0, 2'd2);
        cyc("R10 sw vs cap", 1, 2'd3, 8'h6D, 0, 0, 2'd0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc("R3 mix", r[0] & r[1], r[3:2], r[15:8], r[4] | r[5], r[6], r[9:8]);
        end
        finish_run();
    end
endmodule